// File: doc/BRIEF.md
# Scratchpad Write-and-Copy Controller

This block stages byte writes for a larger byte-addressed memory in a 32-byte scratchpad. A host-side front end turns line activity into byte events: a command strobe with a command code, received bytes with a valid flag, an end-of-transaction pulse, and a count of bits left over after the last full byte. A write transaction carries a 16-bit target address and then data. The data lands in the scratchpad starting at the offset given by the address's low five bits.

While the write runs, the block keeps the ending offset and a partial-byte flag, and it accumulates a CRC-16 over the whole transaction. When the write reaches the top of the scratchpad, the host can shift out the inverted CRC one bit at a time. The address and status registers can be read back at all times. A separate copy command moves the staged bytes into main memory, one byte per clock. The copy runs only if the host echoes all three registers exactly. A mission-lock input keeps one address window from being written.

Top module: `scratch_copy_ctrl`

## Requirements
- R1: After reset `ta_out` and `es_out` are zero, and `crc_valid` and `mem_we` are low.
- R2: A write starts with `cmd_code` 8'h0F on `cmd_stb`. The next two valid bytes load `ta_out[7:0]` and then `ta_out[15:8]`.
- R3: Data bytes after the address are stored from offset `ta_out[4:0]` upward, one offset per byte. Once the byte at offset 31 is stored, any further bytes in that transaction are ignored.
- R4: `es_out[4:0]` holds the offset of the last stored byte.
- R5: A write that ends with a nonzero `tail_bits` sets `es_out[5]`. A write that ends with a zero `tail_bits` clears it. The leftover bits are never stored.
- R6: `es_out[7]` is the copy-accepted flag and `es_out[6]` always reads 0.
- R7: If the write stored a byte at offset 31, the cycle after `xfer_end` raises `crc_valid`. `crc_bit` then presents the bitwise-inverted CRC-16, least-significant bit first, and each `crc_shift` pulse advances it by one bit. After 16 shifts `crc_valid` drops. The CRC starts at zero, uses the reflected polynomial 16'hA001 and processes each byte LSB first. It covers 8'h0F, the low address byte, the high address byte and every stored data byte.
- R8: A write that ends without storing offset 31 never raises `crc_valid`.
- R9: The copy command is `cmd_code` 8'h55. If the next three bytes equal `ta_out[7:0]`, `ta_out[15:8]` and `es_out`, the block pulses `mem_we` on consecutive cycles. For offsets T through E it writes scratchpad byte T+k to address `ta_out`+k, and then sets `es_out[7]`.
- R10: If any of the three copy bytes differs, `mem_we` stays low and `es_out[7]` keeps its value.
- R11: While `lock_in` is high, copy writes to addresses 16'h0200 through 16'h0213 are suppressed (`mem_we` low). The other bytes of the same copy are still written.
- R12: A write command clears `es_out[7]` and `es_out[5]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_stb | input | 1 | Command code present |
| cmd_code | input | 8 | Command code |
| rx_valid | input | 1 | Received byte present |
| rx_byte | input | 8 | Received byte |
| xfer_end | input | 1 | End of transaction |
| tail_bits | input | 3 | Bits received after the last full byte |
| crc_shift | input | 1 | Advance the CRC output by one bit |
| lock_in | input | 1 | Mission lock for the protected window |
| crc_valid | output | 1 | Inverted CRC is being offered |
| crc_bit | output | 1 | Current CRC output bit |
| ta_out | output | 16 | Target address register |
| es_out | output | 8 | Ending offset and status register |
| mem_we | output | 1 | Main memory write enable |
| mem_addr | output | 16 | Main memory byte address |
| mem_wdata | output | 8 | Main memory write data |

## Verification
Random writes use random start offsets, lengths from zero to past the top of the scratchpad, and random partial tails. Together they separate correct offset tracking, overflow discard and the partial-flag state, and the CRC readout checks the byte order the CRC covers. Each write is followed by a copy whose echo is either correct or corrupted in one of the three bytes, so the exact-match rule is tested field by field. Directed cases cover overflow from a high offset and a copy across the locked window, where only part of the copy may reach memory.

// File: rtl/scratch_copy_ctrl.sv
module scratch_copy_ctrl #(
  parameter logic [7:0]  WRITE_CODE = 8'h0F,
  parameter logic [7:0]  COPY_CODE  = 8'h55,
  parameter int          SP_BYTES   = 32,
  parameter logic [15:0] LOCK_LO    = 16'h0200,
  parameter logic [15:0] LOCK_HI    = 16'h0213
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_stb,
  input  logic [7:0]  cmd_code,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        xfer_end,
  input  logic [2:0]  tail_bits,
  input  logic        crc_shift,
  input  logic        lock_in,
  output logic        crc_valid,
  output logic        crc_bit,
  output logic [15:0] ta_out,
  output logic [7:0]  es_out,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata
);
  localparam int OW = $clog2(SP_BYTES);
  localparam logic [OW-1:0] LAST = OW'(SP_BYTES - 1);

  typedef enum logic [3:0] {IDLE, W_TA1, W_TA2, W_DATA, W_CRC,
                            C_A1, C_A2, C_ES, C_RUN} st_t;

  st_t           st;
  logic [15:0]   ta, cp_addr, crc, sh;
  logic [OW-1:0] ptr, eoff;
  logic          pf, aa, full, match;
  logic [3:0]    bcnt;
  logic [7:0]    sp [SP_BYTES];
  logic          sp_we, in_lock;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction

  assign es_out    = 8'({aa, 1'b0, pf, eoff});
  assign ta_out    = ta;
  assign crc_valid = (st == W_CRC);
  assign crc_bit   = sh[0];
  assign in_lock   = lock_in && cp_addr >= LOCK_LO && cp_addr <= LOCK_HI;
  assign mem_we    = (st == C_RUN) && !in_lock;
  assign mem_addr  = cp_addr;
  assign mem_wdata = sp[ptr];
  assign sp_we     = !cmd_stb && st == W_DATA && !xfer_end && rx_valid && !full;

  always_ff @(posedge clk)
    if (sp_we) sp[ptr] <= rx_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; ta <= '0; cp_addr <= '0; crc <= '0; sh <= '0;
      ptr <= '0; eoff <= '0; pf <= 1'b0; aa <= 1'b0; full <= 1'b0;
      match <= 1'b0; bcnt <= '0;
    end else if (cmd_stb) begin
      if (cmd_code == WRITE_CODE) begin
        st <= W_TA1; crc <= crc_step(16'h0000, cmd_code);
        aa <= 1'b0; pf <= 1'b0; full <= 1'b0;
      end else if (cmd_code == COPY_CODE) begin
        st <= C_A1; match <= 1'b1;
      end else
        st <= IDLE;
    end else begin
      case (st)
        W_TA1:
          if (xfer_end) st <= IDLE;
          else if (rx_valid) begin
            ta[7:0] <= rx_byte; crc <= crc_step(crc, rx_byte); st <= W_TA2;
          end
        W_TA2:
          if (xfer_end) st <= IDLE;
          else if (rx_valid) begin
            ta[15:8] <= rx_byte; crc <= crc_step(crc, rx_byte);
            ptr <= ta[OW-1:0]; eoff <= ta[OW-1:0]; st <= W_DATA;
          end
        W_DATA:
          if (xfer_end) begin
            pf <= (tail_bits != 3'd0);
            if (full) begin
              st <= W_CRC; sh <= ~crc; bcnt <= '0;
            end else
              st <= IDLE;
          end else if (rx_valid && !full) begin
            eoff <= ptr; ptr <= ptr + 1'b1;
            full <= (ptr == LAST);
            crc  <= crc_step(crc, rx_byte);
          end
        W_CRC:
          if (crc_shift) begin
            sh <= sh >> 1; bcnt <= bcnt + 1'b1;
            if (bcnt == 4'd15) st <= IDLE;
          end
        C_A1:
          if (xfer_end) st <= IDLE;
          else if (rx_valid) begin
            match <= (rx_byte == ta[7:0]); st <= C_A2;
          end
        C_A2:
          if (xfer_end) st <= IDLE;
          else if (rx_valid) begin
            match <= match && (rx_byte == ta[15:8]); st <= C_ES;
          end
        C_ES:
          if (xfer_end) st <= IDLE;
          else if (rx_valid) begin
            if (match && rx_byte == es_out) begin
              st <= C_RUN; ptr <= ta[OW-1:0]; cp_addr <= ta;
            end else
              st <= IDLE;
          end
        C_RUN:
          if (ptr == eoff) begin
            aa <= 1'b1; st <= IDLE;
          end else begin
            ptr <= ptr + 1'b1; cp_addr <= cp_addr + 16'd1;
          end
        default: st <= IDLE;
      endcase
    end
  end

  // R7
  crc_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_valid) |-> ($past(xfer_end) && es_out[OW-1:0] == LAST));

  // R12
  wr_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_code == WRITE_CODE) |=> (!es_out[7] && !es_out[5]));

  // R9
  copy_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_RUN && $past(st) == C_RUN) |-> mem_addr == $past(mem_addr) + 16'd1);

  // R9
  aa_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(es_out[7]) |-> $past(st) == C_RUN);

  // R10
  echo_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_ES && rx_valid && !cmd_stb && !xfer_end && rx_byte != es_out) |=> !mem_we);

  // R6
  es_bit6_chk: assert property (@(posedge clk) disable iff (!rst_n) !es_out[6]);
endmodule

// File: tb/sim_scratch_copy_ctrl.sv
`timescale 1ns/1ps
module sim_scratch_copy_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_stb = 0, rx_valid = 0, xfer_end = 0, crc_shift = 0, lock_in = 0;
  logic [7:0] cmd_code = 0, rx_byte = 0;
  logic [2:0] tail_bits = 0;
  logic crc_valid, crc_bit, mem_we;
  logic [15:0] ta_out, mem_addr;
  logic [7:0] es_out, mem_wdata;

  int total = 0, bad = 0, wn = 0;
  bit done = 0;
  logic [15:0] wlog_a [64];
  logic [7:0]  wlog_d [64];
  logic [7:0]  msp [32];
  logic [15:0] g_a;
  logic [4:0]  g_e;

  always #2 clk = ~clk;

  scratch_copy_ctrl u0 (.clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .xfer_end(xfer_end), .tail_bits(tail_bits),
    .crc_shift(crc_shift), .lock_in(lock_in), .crc_valid(crc_valid), .crc_bit(crc_bit),
    .ta_out(ta_out), .es_out(es_out), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata));

  always @(negedge clk)
    if (rst_n && mem_we && wn < 64) begin
      wlog_a[wn] = mem_addr; wlog_d[wn] = mem_wdata; wn = wn + 1;
    end

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    logic [7:0] b = d;
    for (int i = 0; i < 8; i++) begin
      logic fb = r[0] ^ b[0];
      r = {1'b0, r[15:1]};
      if (fb) r = r ^ 16'hA001;
      b = b >> 1;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #1; endtask
  task automatic send_cmd(input logic [7:0] c);
    cmd_stb = 1; cmd_code = c; tick; cmd_stb = 0;
  endtask
  task automatic send_byte(input logic [7:0] b);
    rx_valid = 1; rx_byte = b; tick; rx_valid = 0;
  endtask
  task automatic end_xfer(input logic [2:0] t);
    xfer_end = 1; tail_bits = t; tick; xfer_end = 0; tail_bits = 0;
  endtask

  task automatic do_write(input logic [15:0] a, input int n, input logic [2:0] tail);
    logic [15:0] c;
    logic [15:0] got;
    logic [4:0] p, e;
    bit f = 0;
    send_cmd(8'h0F);
    send_byte(a[7:0]); send_byte(a[15:8]);
    c = ref_crc(16'h0000, 8'h0F); c = ref_crc(c, a[7:0]); c = ref_crc(c, a[15:8]);
    p = a[4:0]; e = a[4:0];
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = 8'($urandom);
      send_byte(b);
      if (!f) begin
        msp[p] = b; e = p; c = ref_crc(c, b);
        if (p == 5'd31) f = 1;
        p = p + 5'd1;
      end
    end
    end_xfer(tail);
    g_a = a; g_e = e;
    chk(ta_out == a, "R2 target address", 32'(ta_out), 32'(a));
    chk(es_out == {2'b00, tail != 3'd0, e}, "R4 R5 R6 R12 status", 32'(es_out),
        32'({2'b00, tail != 3'd0, e}));
    if (f) begin
      chk(crc_valid, "R7 crc offered", 32'(crc_valid), 1);
      for (int k = 0; k < 16; k++) begin
        got[k] = crc_bit; crc_shift = 1; tick; crc_shift = 0;
      end
      chk(got == ~c, "R7 inverted crc", 32'(got), 32'(~c));
      chk(!crc_valid, "R7 crc ends", 32'(crc_valid), 0);
    end else
      chk(!crc_valid, "R8 no crc", 32'(crc_valid), 0);
  endtask

  task automatic do_copy(input bit good);
    logic [7:0] e0, e1, e2;
    int sel, m;
    bit okall;
    wn = 0;
    e0 = ta_out[7:0]; e1 = ta_out[15:8]; e2 = es_out;
    if (!good) begin
      sel = $urandom_range(0, 2);
      if (sel == 0) e0 ^= 8'h01 << $urandom_range(0, 7);
      else if (sel == 1) e1 ^= 8'h01 << $urandom_range(0, 7);
      else e2 ^= 8'h20;
    end
    send_cmd(8'h55);
    send_byte(e0); send_byte(e1); send_byte(e2);
    repeat (40) tick;
    if (!good) begin
      chk(wn == 0, "R10 no write on mismatch", 32'(wn), 0);
      chk(!es_out[7], "R10 accept flag clear", 32'(es_out[7]), 0);
      return;
    end
    m = 0; okall = 1;
    for (int off = int'(g_a[4:0]); off <= int'(g_e); off++) begin
      logic [15:0] ad = g_a + 16'(off - int'(g_a[4:0]));
      if (lock_in && ad >= 16'h0200 && ad <= 16'h0213) continue;
      if (m >= wn || wlog_a[m] != ad || wlog_d[m] != msp[off]) okall = 0;
      m++;
    end
    chk(wn == m, "R9 R11 write count", 32'(wn), 32'(m));
    chk(okall, "R3 R9 R11 copied bytes", 32'(okall), 1);
    chk(es_out[7], "R9 accept flag", 32'(es_out[7]), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) tick;
    chk(ta_out == 0 && es_out == 0, "R1 reset regs", 32'({ta_out, es_out}), 0);
    chk(!crc_valid && !mem_we, "R1 reset outputs", 32'({crc_valid, mem_we}), 0);
    rst_n = 1; tick;

    do_write(16'h0103, 5, 3'd0);
    do_copy(1);
    do_write(16'h0040, 4, 3'd5);
    chk(!es_out[7], "R12 accept cleared", 32'(es_out[7]), 0);
    do_copy(0);

    do_write(16'h0114, 40, 3'd0);
    chk(es_out[4:0] == 5'd31, "R3 overflow end offset", 32'(es_out[4:0]), 31);
    do_copy(1);

    lock_in = 1;
    do_write(16'h020C, 20, 3'd0);
    do_copy(1);
    chk(wn == 12, "R11 locked window skipped", 32'(wn), 12);
    lock_in = 0;

    for (int it = 0; it < 25; it++) begin
      logic [15:0] a = 16'($urandom) & 16'h01FF;
      int n = $urandom_range(0, 36);
      logic [2:0] t = ($urandom_range(0, 2) == 0) ? 3'($urandom_range(1, 7)) : 3'd0;
      do_write(a, n, t);
      if (n > 0) do_copy($urandom_range(0, 3) != 0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule